// File: doc/BRIEF.md
# Pipelined Synchronous SRAM Controller with Delayed Output Turn-Off

This block wraps a small on-chip memory array, four byte lanes wide, in a fully registered synchronous front end. On every rising clock edge it captures the address, write data, the three chip-select lines, the global write strobe, the byte-write enable and the per-lane write strobes. A captured write is committed to the array on the following edge without further handshake. A captured read fetches the array on the following edge into an output register, so every access has a fixed two-edge latency and a new access can start on every clock.

The output drive has two controls. The first is a clocked enable that stays on for one extra cycle when the chip moves from a read to a deselected cycle, so another bank sharing the data bus can take over without a wait state. The second is an output-enable input that acts asynchronously on that drive. A tri-state bus is modelled as a data vector that reads zero while not driven, together with a drive-enable flag.

Top module: `pdsram_core`

## Requirements
- R1: The chip is selected only when `cs_a_n` is 0, `cs_b` is 1 and `cs_c_n` is 0. A deselected cycle neither alters the array nor loads the output register.
- R2: A read whose address is captured at rising edge E places that word on `dout` after edge E+1, with `dout_en` high when `oe_n` is low.
- R3: When `gwr_n` is low on a selected cycle, all four lanes are written, whatever `bwr_n` and `lane_wr_n` hold.
- R4: When `gwr_n` is high and `bwr_n` is low on a selected cycle, lane k (`din[8k+7:8k]`) is written exactly when `lane_wr_n[k]` is 0. The other lanes keep their contents.
- R5: When `gwr_n` and `bwr_n` are both high on a selected cycle, the cycle is a read and `lane_wr_n` has no effect on the array.
- R6: A selected write cycle, including one with `bwr_n` low and every `lane_wr_n` bit high, turns the drive off in its output slot with no extra cycle. A write with no lanes enabled changes no array contents.
- R7: After a read, a following deselected cycle keeps the drive on for one more cycle, showing the last read word. A second consecutive deselected cycle turns it off.
- R8: `dout_en` equals the clocked drive enable AND NOT `oe_n`, and it follows `oe_n` with no clock edge. `dout` is zero whenever `dout_en` is low.
- R9: A read captured on the edge directly after a write to the same address returns the newly written lanes merged with the old ones.
- R10: While `rst_n` is low and after its release, the drive is off and `dout` is zero until the first read reaches the output.
- R11: Reads on consecutive cycles each deliver their own word on consecutive cycles, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the control pipeline |
| addr | input | $clog2(DEPTH) | Word address |
| din | input | 32 | Write data, four 8-bit lanes |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b | input | 1 | Chip select, active high |
| cs_c_n | input | 1 | Chip select, active low |
| gwr_n | input | 1 | Global write, all lanes, active low |
| bwr_n | input | 1 | Byte-write enable, active low |
| lane_wr_n | input | 4 | Per-lane write strobes, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dout | output | 32 | Read data, zero when not driven |
| dout_en | output | 1 | Data drive enable |

## Verification
The hardest situation to reach from the ports is a read of an address in the cycle right after that address received a partial lane write. This case needs a narrow address range and the right order of strobes. Random stimulus therefore draws half of its addresses from eight words and mixes global, partial and zero-lane writes with reads. Directed sequences also force a read followed by one and then two deselected cycles, with each of the three select lines used as the one that deselects. The asynchronous output enable is toggled between clock edges while a read word is being driven.

// File: rtl/pdsram_pkg.sv
package pdsram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int DW     = LANES * LANE_W;

  typedef struct packed {
    logic             sel;
    logic             wr;
    logic [LANES-1:0] mask;
  } ctl_t;

  // three-line chip select
  function automatic logic chip_sel(input logic a_n, input logic b, input logic c_n);
    return !a_n && b && !c_n;
  endfunction

  function automatic logic is_write(input logic g_n, input logic be_n);
    return !g_n || !be_n;
  endfunction

  // lanes written: global wins, else per-lane strobes gated by byte enable
  function automatic logic [LANES-1:0] lane_mask(input logic g_n, input logic be_n,
                                                 input logic [LANES-1:0] lw_n);
    if (!g_n)       return '1;
    else if (!be_n) return ~lw_n;
    else            return '0;
  endfunction
endpackage

// File: rtl/pdsram_in_stage.sv
module pdsram_in_stage
  import pdsram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    din_i,
  input  logic             cs_a_n,
  input  logic             cs_b,
  input  logic             cs_c_n,
  input  logic             gwr_n,
  input  logic             bwr_n,
  input  logic [LANES-1:0] lane_wr_n,
  output logic [AW-1:0]    addr_q,
  output logic [DW-1:0]    din_q,
  output ctl_t             ctl_q
);
  ctl_t ctl_d;

  always_comb begin
    ctl_d.sel  = chip_sel(cs_a_n, cs_b, cs_c_n);
    ctl_d.wr   = is_write(gwr_n, bwr_n);
    ctl_d.mask = lane_mask(gwr_n, bwr_n, lane_wr_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      din_q  <= '0;
      ctl_q  <= '0;
    end else begin
      addr_q <= addr_i;
      din_q  <= din_i;
      ctl_q  <= ctl_d;
    end
  end
endmodule

// File: rtl/pdsram_array.sv
module pdsram_array
  import pdsram_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [LANES-1:0] wmask,
  input  logic [AW-1:0]    waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [AW-1:0]    raddr,
  output logic [DW-1:0]    rdata
);
  logic [DW-1:0] mem [DEPTH];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (we && wmask[g])
        mem[waddr][g*LANE_W +: LANE_W] <= wdata[g*LANE_W +: LANE_W];
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/pdsram_out_stage.sv
module pdsram_out_stage
  import pdsram_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_fire,
  input  logic          desel,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] dq,
  output logic          rdv_q,
  output logic          drive_on
);
  logic rdv_q2;
  logic desel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq      <= '0;
      rdv_q   <= 1'b0;
      rdv_q2  <= 1'b0;
      desel_q <= 1'b0;
    end else begin
      if (rd_fire) dq <= rdata;
      rdv_q   <= rd_fire;
      rdv_q2  <= rdv_q;
      desel_q <= desel;
    end
  end

  // hold drive one extra slot only when a read is followed by a deselect
  assign drive_on = rdv_q || (rdv_q2 && desel_q);
endmodule

// File: rtl/pdsram_core.sv
module pdsram_core
  import pdsram_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    din,
  input  logic             cs_a_n,
  input  logic             cs_b,
  input  logic             cs_c_n,
  input  logic             gwr_n,
  input  logic             bwr_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic             oe_n,
  output logic [DW-1:0]    dout,
  output logic             dout_en
);
  logic [AW-1:0]    addr_s1;
  logic [DW-1:0]    din_s1;
  ctl_t             ctl_s1;
  logic             sel_s1, wr_s1;
  logic [LANES-1:0] wmask_s1;
  logic             wr_fire, rd_fire;
  logic [DW-1:0]    rdata;
  logic [DW-1:0]    dq;
  logic             rdv_q, drive_on;

  pdsram_in_stage #(.AW(AW)) in_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .din_i(din),
    .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n),
    .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_wr_n(lane_wr_n),
    .addr_q(addr_s1), .din_q(din_s1), .ctl_q(ctl_s1)
  );

  assign sel_s1   = ctl_s1.sel;
  assign wr_s1    = ctl_s1.wr;
  assign wmask_s1 = ctl_s1.mask;
  assign wr_fire  = sel_s1 && wr_s1;
  assign rd_fire  = sel_s1 && !wr_s1;

  pdsram_array #(.DEPTH(DEPTH), .AW(AW)) arr_i (
    .clk(clk), .we(wr_fire), .wmask(wmask_s1), .waddr(addr_s1),
    .wdata(din_s1), .raddr(addr_s1), .rdata(rdata)
  );

  pdsram_out_stage out_i (
    .clk(clk), .rst_n(rst_n), .rd_fire(rd_fire), .desel(!sel_s1),
    .rdata(rdata), .dq(dq), .rdv_q(rdv_q), .drive_on(drive_on)
  );

  assign dout_en = drive_on && !oe_n;
  assign dout    = dout_en ? dq : '0;
endmodule

// File: rtl/pdsram_chk.sv
module pdsram_chk
  import pdsram_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cs_a_n,
  input logic             cs_b,
  input logic             cs_c_n,
  input logic             gwr_n,
  input logic             bwr_n,
  input logic [LANES-1:0] lane_wr_n,
  input logic             oe_n,
  input logic             sel_s1,
  input logic             wr_s1,
  input logic [LANES-1:0] wmask_s1,
  input logic [DW-1:0]    dq,
  input logic             rdv_q,
  input logic             drive_on,
  input logic             dout_en
);
  logic picked;
  assign picked = (cs_a_n == 1'b0) && (cs_b == 1'b1) && (cs_c_n == 1'b0);

  assert_desel_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !picked |=> !sel_s1);
  assert_desel_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_s1 |=> $stable(dq));
  assert_read_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_s1 && !wr_s1) |=> drive_on);
  assert_global_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (picked && !gwr_n) |=> (wmask_s1 == {LANES{1'b1}}));
  assert_lane_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (picked && gwr_n && !bwr_n) |=> (wmask_s1 == ~$past(lane_wr_n)));
  assert_read_decode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (picked && gwr_n && bwr_n) |=> (sel_s1 && !wr_s1));
  assert_write_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_s1 && wr_s1) |=> (!drive_on && $stable(dq)));
  assert_extra_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdv_q && !sel_s1) |=> drive_on);
  assert_no_third_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdv_q && !sel_s1) |=> !drive_on);
  assert_oe_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_en);
  assert_oe_gate_neg_R8: assert property (@(negedge clk) disable iff (!rst_n)
    oe_n |-> !dout_en);
endmodule

bind pdsram_core pdsram_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n),
  .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_wr_n(lane_wr_n), .oe_n(oe_n),
  .sel_s1(sel_s1), .wr_s1(wr_s1), .wmask_s1(wmask_s1), .dq(dq),
  .rdv_q(rdv_q), .drive_on(drive_on), .dout_en(dout_en)
);

// File: tb/pdsram_core_tb_top.sv
module pdsram_core_tb_top;
  localparam int CLK_P = 10;
  localparam int DEPTH = 64;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   din = '0;
  logic          cs_a_n = 1'b1, cs_b = 1'b0, cs_c_n = 1'b1;
  logic          gwr_n = 1'b1, bwr_n = 1'b1;
  logic [3:0]    lane_wr_n = 4'hF;
  logic          oe_n = 1'b0;
  logic [31:0]   dout;
  logic          dout_en;

  int n_chk = 0;
  int n_err = 0;

  logic [31:0] mdl [DEPTH];
  string       mtag [DEPTH];
  logic        cur_on = 1'b0, nxt_on = 1'b0;
  logic [31:0] cur_dq = '0, nxt_dq = '0;
  string       cur_tag = "R10", nxt_tag = "R10";
  logic        prev_rd = 1'b0;
  logic        lw_valid = 1'b0;
  int          lw_addr = 0;

  always #(CLK_P/2) clk = ~clk;

  pdsram_core #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
    .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n),
    .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_wr_n(lane_wr_n), .oe_n(oe_n),
    .dout(dout), .dout_en(dout_en)
  );

  function automatic logic [3:0] bench_lanes(logic g, logic be, logic [3:0] lw);
    logic [3:0] m;
    for (int k = 0; k < 4; k++) m[k] = (g == 1'b0) || ((be == 1'b0) && (lw[k] == 1'b0));
    return m;
  endfunction

  task automatic check(string tag);
    logic        een;
    logic [31:0] ed;
    een = cur_on && (oe_n == 1'b0);
    ed  = een ? cur_dq : 32'h0;
    n_chk++;
    if (dout_en !== een || dout !== ed) begin
      n_err++;
      $display("FAIL %s: dout_en=%0b dout=%h expected dout_en=%0b dout=%h",
               tag, dout_en, dout, een, ed);
    end
  endtask

  // one bus cycle; called at a falling edge
  task automatic cyc(logic c1, logic c2, logic c3, logic g, logic be,
                     logic [3:0] lw, logic oe, int a, logic [31:0] d);
    logic sel, wr, rd;
    logic [3:0] m;
    string t;
    check(cur_tag);
    cur_on = nxt_on; cur_dq = nxt_dq; cur_tag = nxt_tag;
    cs_a_n = c1; cs_b = c2; cs_c_n = c3; gwr_n = g; bwr_n = be;
    lane_wr_n = lw; oe_n = oe; addr = AW'(a); din = d;
    sel = !c1 && c2 && !c3;
    wr  = !g || !be;
    rd  = sel && !wr;
    m   = bench_lanes(g, be, lw);
    if (rd) begin
      nxt_dq = mdl[a];
      t = (lw_valid && lw_addr == a) ? "R9" : mtag[a];
      if (prev_rd) t = {t, " R11"};
    end else if (!sel) t = prev_rd ? "R7" : "R1";
    else t = "R6";
    nxt_on  = rd || (prev_rd && !sel);
    nxt_tag = t;
    if (sel && wr) begin
      for (int k = 0; k < 4; k++) if (m[k]) mdl[a][k*8 +: 8] = d[k*8 +: 8];
      if (m == 4'h0) mtag[a] = "R6";
      else mtag[a] = !g ? "R3" : (be ? "R5" : "R4");
    end else if (!sel && wr) mtag[a] = "R1";
    else if (rd && lw != 4'hF) mtag[a] = "R5";
    lw_valid = sel && wr;
    lw_addr  = a;
    prev_rd  = rd;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd_c(int a);
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, 1'b0, a, 32'h0);
  endtask

  task automatic oe_probe();
    #2 oe_n = 1'b1;
    #1;
    n_chk++;
    if (dout_en !== 1'b0 || dout !== 32'h0) begin
      n_err++;
      $display("FAIL R8: dout_en=%0b dout=%h expected dout_en=0 dout=0", dout_en, dout);
    end
    oe_n = 1'b0;
    #1 check("R8");
  endtask

  initial begin
    void'($urandom(32'h5eed_0123));
    for (int i = 0; i < DEPTH; i++) mtag[i] = "R3";
    repeat (3) @(negedge clk);
    check("R10");
    rst_n = 1'b1;
    @(negedge clk);
    check("R10");
    // prefill every word with a global write, byte strobes scrambled (R3)
    for (int i = 0; i < DEPTH; i++)
      cyc(1'b0, 1'b1, 1'b0, 1'b0, $urandom_range(0, 1), 4'($urandom), 1'b0, i, $urandom);
    // R9: partial write then immediate read of the same word
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'b1101, 1'b0, 3, 32'hA5C3_7E19);
    rd_c(3);
    // R7: read, then deselects via each select line
    rd_c(4); cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'h0, 1'b0, 4, 32'h1);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'hF, 1'b0, 4, 32'h0);
    rd_c(5); cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 1'b0, 5, 32'h0);
    oe_probe();
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'hF, 1'b0, 5, 32'h0);
    rd_c(4);
    // R6: zero-lane write then read back
    rd_c(6);
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'hF, 1'b0, 6, 32'hFFFF_FFFF);
    rd_c(6);
    // R5: reads with random lane strobes; R11 back to back
    for (int i = 0; i < 6; i++)
      cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'($urandom), 1'b0, i, $urandom);
    rd_c(0); rd_c(1);
    oe_probe();
    // constrained random
    for (int i = 0; i < 3000; i++) begin
      int r, a;
      logic c1, c2, c3, g, be, oe;
      logic [3:0] lw;
      r  = $urandom_range(0, 99);
      a  = ($urandom_range(0, 1) == 1) ? $urandom_range(0, 7) : $urandom_range(0, DEPTH-1);
      c1 = 1'b0; c2 = 1'b1; c3 = 1'b0;
      g  = 1'b1; be = 1'b1; lw = 4'($urandom);
      oe = ($urandom_range(0, 9) == 0);
      if (r < 15) begin
        case ($urandom_range(0, 2))
          0: c1 = 1'b1;
          1: c2 = 1'b0;
          default: c3 = 1'b1;
        endcase
        g = 1'($urandom); be = 1'($urandom);
      end else if (r < 55) begin
        g = 1'b1; be = 1'b1;
      end else if (r < 72) begin
        g = 1'b0; be = 1'($urandom);
      end else if (r < 95) begin
        be = 1'b0;
      end else begin
        be = 1'b0; lw = 4'hF;
      end
      cyc(c1, c2, c3, g, be, lw, oe, a, $urandom);
      if ($urandom_range(0, 49) == 0) oe_probe();
    end
    rd_c(2);
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 1'b0, 0, 32'h0);
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 1'b0, 0, 32'h0);
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 1'b0, 0, 32'h0);
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule